// File: doc/BRIEF.md
# General-Purpose I/O Bank with Two Interrupt Lines

This block is a 32-pin general-purpose I/O bank sitting behind a simple 32-bit register port. Each pin can either be driven from an output data register or read as an input. Every input passes through a synchronizer before anything else sees it. The bank can watch each pin for four kinds of event: a low level, a high level, a rising edge and a falling edge. Each kind is armed by its own per-pin register.

A detected event is recorded in two separate sticky status registers. Each status register has its own per-pin enable mask and its own registered interrupt output, so two different processors can each take their own subset of pins. The enable masks and the output data can also be changed one bit at a time, without a read-modify-write, through set and clear alias addresses. A control bit triggers a soft reset of the whole bank. The wakeup and debounce registers are storage only and have no effect on the pins.

The register port is single-cycle. A write is committed on the rising clock edge where `bus_wr` is high. Read data is combinational from the address.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: Direction register (offset 0x34) bit = 1 makes the pin an input (`pin_drive` bit 0). Bit = 0 makes it an output (`pin_drive` bit 1), and `pin_out` always carries the output data register (offset 0x3C).
- R2: Each pin input passes through two flops. The input register (offset 0x38) shows a pin change after two rising edges and not after one.
- R3: The rising-detect register (0x48) arms a 0-to-1 event and the falling-detect register (0x4C) arms a 1-to-0 event on the synchronized input. An edge is recorded once, even if the pin then stays at its new level.
- R4: Level register 0x40 arms a low-level event and level register 0x44 arms a high-level event. A level event still present re-sets its status bit on the clock after it is cleared.
- R5: An event sets the pin's bit in both status registers (line 1 at 0x18, line 2 at 0x28) whatever the enables hold. A status bit stays set until cleared or reset.
- R6: Line n's interrupt output is high one clock after status n AND enable n (line 1 enable at 0x1C, line 2 at 0x2C) is non-zero. The two lines are independent.
- R7: Writing 1s to a status register clears those bits. The clear wins over an event arriving in the same cycle. Zero bits are untouched.
- R8: Enable alias addresses: 0x64 and 0x74 set the written 1 bits of enable 1 and enable 2; 0x60 and 0x70 clear them. Zero bits have no effect, and reading any alias returns the enable value.
- R9: Output data aliases: 0x94 sets and 0x90 clears the written 1 bits of the output data. Reading either alias returns the output data.
- R10: Writing a 1 to bit 1 of the control register (0x10) resets every register in the bank on the next clock. The status register (0x14) bit 0 reads 0 during that clock and 1 otherwise.
- R11: After reset the direction register is all ones, and the output data, detect, enable and status registers are all zero. Both interrupt outputs are low.
- R12: Addresses outside the map read as zero and ignore writes. The wakeup (0x20, set 0x84, clear 0x80) and debounce (0x50, 0x54, 8 bits) registers only store values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, committed on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data driven to the pins |
| pin_drive | output | 32 | Per-pin output enable (1 = driven) |
| irq_l1 | output | 1 | Interrupt output of line 1 |
| irq_l2 | output | 1 | Interrupt output of line 2 |

## Verification
The hardest case to reach is a level event racing a status clear. The bit has to drop for exactly one clock and then come back, and that one-clock gap is only visible if the read lands right after the clearing edge. The stimulus first holds a pin at an armed level long enough for both synchronizer flops and the status latch to settle. It then issues the clear and reads status in the next low clock phase and again one cycle later. A similar case is a level-low event on a pin that is already low when the level register is armed. The bench raises that pin and waits out the synchronizer before clearing, so that the clear actually sticks.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets and per-line address helpers for the GPIO bank.
// Assumes byte offsets fit in 8 bits and that there are exactly two interrupt lines.
package gpio_bank_pkg;

    localparam int NUM_LINES = 2;
    localparam int SRST_BIT  = 1;

    localparam logic [7:0] OFS_SYSCFG  = 8'h10;
    localparam logic [7:0] OFS_SYSSTAT = 8'h14;
    localparam logic [7:0] OFS_STAT1   = 8'h18;
    localparam logic [7:0] OFS_EN1     = 8'h1C;
    localparam logic [7:0] OFS_WAKE    = 8'h20;
    localparam logic [7:0] OFS_STAT2   = 8'h28;
    localparam logic [7:0] OFS_EN2     = 8'h2C;
    localparam logic [7:0] OFS_DIR     = 8'h34;
    localparam logic [7:0] OFS_DIN     = 8'h38;
    localparam logic [7:0] OFS_DOUT    = 8'h3C;
    localparam logic [7:0] OFS_LVLLO   = 8'h40;
    localparam logic [7:0] OFS_LVLHI   = 8'h44;
    localparam logic [7:0] OFS_RISE    = 8'h48;
    localparam logic [7:0] OFS_FALL    = 8'h4C;
    localparam logic [7:0] OFS_DBEN    = 8'h50;
    localparam logic [7:0] OFS_DBTIME  = 8'h54;
    localparam logic [7:0] OFS_CLREN1  = 8'h60;
    localparam logic [7:0] OFS_SETEN1  = 8'h64;
    localparam logic [7:0] OFS_CLREN2  = 8'h70;
    localparam logic [7:0] OFS_SETEN2  = 8'h74;
    localparam logic [7:0] OFS_CLRWAKE = 8'h80;
    localparam logic [7:0] OFS_SETWAKE = 8'h84;
    localparam logic [7:0] OFS_CLRDOUT = 8'h90;
    localparam logic [7:0] OFS_SETDOUT = 8'h94;

    // Offset of the status register of a given line.
    function automatic logic [7:0] ofs_stat(input int line);
        return (line == 0) ? OFS_STAT1 : OFS_STAT2;
    endfunction

    // Offset of the direct enable register of a given line.
    function automatic logic [7:0] ofs_en(input int line);
        return (line == 0) ? OFS_EN1 : OFS_EN2;
    endfunction

    // Offset of the enable set alias of a given line.
    function automatic logic [7:0] ofs_seten(input int line);
        return (line == 0) ? OFS_SETEN1 : OFS_SETEN2;
    endfunction

    // Offset of the enable clear alias of a given line.
    function automatic logic [7:0] ofs_clren(input int line);
        return (line == 0) ? OFS_CLREN1 : OFS_CLREN2;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: per-pin input synchronizer with a one-cycle history register.
// Assumes pin inputs are fully asynchronous; STAGES >= 2.
// The last stage drives pin_sync, and pin_prev is pin_sync one clock later.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_prev
);
    logic         clr;
    logic [W-1:0] stage [STAGES];

    assign clr = !rst_n || soft_rst;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (clr) stage[0] <= '0;
        else     stage[0] <= pin_raw;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (clr) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    endgenerate

    assign pin_sync = stage[STAGES-1];

    // History flop used for edge comparison.
    always_ff @(posedge clk) begin
        if (clr) pin_prev <= '0;
        else     pin_prev <= pin_sync;
    end
endmodule

// File: rtl/gpio_evt_detect.sv
// Module: combinational per-pin event detector.
// Assumes cur/prev are synchronized values one clock apart.
// Raises evt for any armed condition among low level, high level, rising edge and falling edge.
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] arm_low,
    input  logic [W-1:0] arm_high,
    input  logic [W-1:0] arm_rise,
    input  logic [W-1:0] arm_fall,
    output logic [W-1:0] evt
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic lvl_hit;
            logic edge_hit;
            // Level conditions come from the current value only.
            assign lvl_hit  = (arm_low[b] && !cur[b]) || (arm_high[b] && cur[b]);
            // Edge conditions need the value before as well.
            assign edge_hit = (arm_rise[b] && cur[b] && !prev[b])
                           || (arm_fall[b] && !cur[b] && prev[b]);
            assign evt[b]   = lvl_hit || edge_hit;
        end
    endgenerate
endmodule

// File: rtl/gpio_alias_reg.sv
// Module: register with direct load plus write-one-to-set and write-one-to-clear ports.
// Assumes at most one of load/set/clr is active per cycle (one bus write at a time).
// Load takes precedence over set/clear if they overlap.
module gpio_alias_reg #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    // Hold, load, or apply bitwise set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) q <= RST_VAL;
        else if (load)          q <= load_val;
        else                    q <= (q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/gpio_irq_line.sv
// Module: one interrupt line made of a sticky status register, an enable mask and a registered output.
// Assumes evt is one clock wide per detection (or held for levels).
// A clear wins over an event on the same bit in the same cycle.
module gpio_irq_line #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] stat_clr,
    input  logic         en_load,
    input  logic [W-1:0] en_load_val,
    input  logic [W-1:0] en_set,
    input  logic [W-1:0] en_clr,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);
    logic clr;
    assign clr = !rst_n || soft_rst;

    // Status latches every event regardless of the mask; write-one-to-clear.
    always_ff @(posedge clk) begin
        if (clr) status <= '0;
        else     status <= (status | evt) & ~stat_clr;
    end

    gpio_alias_reg #(.W(W), .RST_VAL('0)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .load     (en_load),
        .load_val (en_load_val),
        .set_bits (en_set),
        .clr_bits (en_clr),
        .q        (enable)
    );

    // Registered interrupt request from masked status.
    always_ff @(posedge clk) begin
        if (clr) irq <= 1'b0;
        else     irq <= |(status & enable);
    end
endmodule

// File: rtl/gpio_dual_irq_bank.sv
// Module: top of the GPIO bank. It holds the register decode, the read mux, the soft reset,
// the synchronizer, the event detection and two interrupt lines.
// Assumes a single-cycle register port (write on the edge, combinational read) and NPINS <= 32.
module gpio_dual_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_drive,
    output logic              irq_l1,
    output logic              irq_l2
);
    localparam int              BUS_W   = 32;
    localparam int              DBT_W   = 8;
    localparam logic [NPINS-1:0] ALL_IN = '1;
    localparam logic [NPINS-1:0] NONE   = '0;

    // True when the address equals a map offset.
    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic [NPINS-1:0] wd;
    logic             srst_q;
    logic [BUS_W-1:0] syscfg_q;
    logic [NPINS-1:0] dir_q, dout_q, lvllo_q, lvlhi_q, rise_q, fall_q;
    logic [NPINS-1:0] wake_q, dben_q;
    logic [DBT_W-1:0] dbtime_q;
    logic [NPINS-1:0] in_sync, in_prev, evt;
    logic [NPINS-1:0] line_stat [NUM_LINES];
    logic [NPINS-1:0] line_en   [NUM_LINES];
    logic [NUM_LINES-1:0] line_irq;

    assign wd = bus_wdata[NPINS-1:0];

    // Soft reset pulse: one clock after the control write.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= bus_wr && at(bus_addr, OFS_SYSCFG) && bus_wdata[SRST_BIT];
    end

    // Control register stores its other bits as placeholders; the reset bit self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q)                   syscfg_q <= '0;
        else if (bus_wr && at(bus_addr, OFS_SYSCFG)) syscfg_q <= bus_wdata & ~(BUS_W'(1) << SRST_BIT);
    end

    gpio_alias_reg #(.W(NPINS), .RST_VAL(ALL_IN)) u_dir (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_DIR)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(dir_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_dout (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_DOUT)), .load_val(wd),
        .set_bits((bus_wr && at(bus_addr, OFS_SETDOUT)) ? wd : NONE),
        .clr_bits((bus_wr && at(bus_addr, OFS_CLRDOUT)) ? wd : NONE),
        .q(dout_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_lvllo (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_LVLLO)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(lvllo_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_lvlhi (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_LVLHI)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(lvlhi_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_rise (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_RISE)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(rise_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_fall (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_FALL)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(fall_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_wake (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_WAKE)), .load_val(wd),
        .set_bits((bus_wr && at(bus_addr, OFS_SETWAKE)) ? wd : NONE),
        .clr_bits((bus_wr && at(bus_addr, OFS_CLRWAKE)) ? wd : NONE),
        .q(wake_q)
    );

    gpio_alias_reg #(.W(NPINS), .RST_VAL('0)) u_dben (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_DBEN)), .load_val(wd),
        .set_bits(NONE), .clr_bits(NONE), .q(dben_q)
    );

    gpio_alias_reg #(.W(DBT_W), .RST_VAL('0)) u_dbtime (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .load(bus_wr && at(bus_addr, OFS_DBTIME)), .load_val(bus_wdata[DBT_W-1:0]),
        .set_bits('0), .clr_bits('0), .q(dbtime_q)
    );

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_q),
        .pin_raw(pin_in), .pin_sync(in_sync), .pin_prev(in_prev)
    );

    gpio_evt_detect #(.W(NPINS)) u_evt (
        .cur(in_sync), .prev(in_prev),
        .arm_low(lvllo_q), .arm_high(lvlhi_q),
        .arm_rise(rise_q), .arm_fall(fall_q),
        .evt(evt)
    );

    genvar l;
    generate
        for (l = 0; l < NUM_LINES; l++) begin : g_line
            logic stat_hit, en_hit, set_hit, clr_hit;
            assign stat_hit = bus_wr && at(bus_addr, ofs_stat(l));
            assign en_hit   = bus_wr && at(bus_addr, ofs_en(l));
            assign set_hit  = bus_wr && at(bus_addr, ofs_seten(l));
            assign clr_hit  = bus_wr && at(bus_addr, ofs_clren(l));

            gpio_irq_line #(.W(NPINS)) u_line (
                .clk         (clk),
                .rst_n       (rst_n),
                .soft_rst    (srst_q),
                .evt         (evt),
                .stat_clr    (stat_hit ? wd : NONE),
                .en_load     (en_hit),
                .en_load_val (wd),
                .en_set      (set_hit ? wd : NONE),
                .en_clr      (clr_hit ? wd : NONE),
                .status      (line_stat[l]),
                .enable      (line_en[l]),
                .irq         (line_irq[l])
            );
        end
    endgenerate

    assign irq_l1    = line_irq[0];
    assign irq_l2    = line_irq[1];
    assign pin_out   = dout_q;
    assign pin_drive = ~dir_q;

    // Read mux: map offsets to register values, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_SYSCFG):  bus_rdata = syscfg_q;
            ADDR_W'(OFS_SYSSTAT): bus_rdata = BUS_W'(!srst_q);
            ADDR_W'(OFS_STAT1):   bus_rdata = BUS_W'(line_stat[0]);
            ADDR_W'(OFS_STAT2):   bus_rdata = BUS_W'(line_stat[1]);
            ADDR_W'(OFS_EN1),
            ADDR_W'(OFS_SETEN1),
            ADDR_W'(OFS_CLREN1):  bus_rdata = BUS_W'(line_en[0]);
            ADDR_W'(OFS_EN2),
            ADDR_W'(OFS_SETEN2),
            ADDR_W'(OFS_CLREN2):  bus_rdata = BUS_W'(line_en[1]);
            ADDR_W'(OFS_WAKE),
            ADDR_W'(OFS_SETWAKE),
            ADDR_W'(OFS_CLRWAKE): bus_rdata = BUS_W'(wake_q);
            ADDR_W'(OFS_DIR):     bus_rdata = BUS_W'(dir_q);
            ADDR_W'(OFS_DIN):     bus_rdata = BUS_W'(in_sync);
            ADDR_W'(OFS_DOUT),
            ADDR_W'(OFS_SETDOUT),
            ADDR_W'(OFS_CLRDOUT): bus_rdata = BUS_W'(dout_q);
            ADDR_W'(OFS_LVLLO):   bus_rdata = BUS_W'(lvllo_q);
            ADDR_W'(OFS_LVLHI):   bus_rdata = BUS_W'(lvlhi_q);
            ADDR_W'(OFS_RISE):    bus_rdata = BUS_W'(rise_q);
            ADDR_W'(OFS_FALL):    bus_rdata = BUS_W'(fall_q);
            ADDR_W'(OFS_DBEN):    bus_rdata = BUS_W'(dben_q);
            ADDR_W'(OFS_DBTIME):  bus_rdata = BUS_W'(dbtime_q);
            default:              bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Module: property checker for the GPIO bank, attached by bind.
// Assumes single-cycle writes and the offsets of gpio_bank_pkg.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              srst_q,
    input logic [NPINS-1:0]  stat1,
    input logic [NPINS-1:0]  stat2,
    input logic [NPINS-1:0]  en1,
    input logic [NPINS-1:0]  en2,
    input logic [NPINS-1:0]  dir,
    input logic              irq_l1,
    input logic              irq_l2
);
    // R6: line 1 output follows masked status one clock later
    a_r6_irq1_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(srst_q) |-> (irq_l1 == $past(|(stat1 & en1))));

    // R6: line 2 output follows masked status one clock later
    a_r6_irq2_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(srst_q) |-> (irq_l2 == $past(|(stat2 & en2))));

    // R7: written ones in status 1 are zero after the write
    a_r7_w1c_line1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT1))
        |=> ((stat1 & $past(bus_wdata[NPINS-1:0])) == '0));

    // R5: status 2 bits persist unless cleared or reset
    a_r5_sticky_line2: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_q && !(bus_wr && bus_addr == ADDR_W'(OFS_STAT2)))
        |=> ((stat2 & $past(stat2)) == $past(stat2)));

    // R8: set alias of line 1 makes the written bits one
    a_r8_set_en1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SETEN1) && !srst_q)
        |=> ((en1 & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R8: clear alias of line 2 makes the written bits zero
    a_r8_clr_en2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLREN2))
        |=> ((en2 & $past(bus_wdata[NPINS-1:0])) == '0));

    // R10: soft reset returns enables and direction to defaults
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (en1 == '0 && en2 == '0 && (&dir)));
endmodule

bind gpio_dual_irq_bank gpio_bank_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .srst_q    (srst_q),
    .stat1     (line_stat[0]),
    .stat2     (line_stat[1]),
    .en1       (line_en[0]),
    .en2       (line_en[1]),
    .dir       (dir_q),
    .irq_l1    (irq_l1),
    .irq_l2    (irq_l2)
);

// File: tb/gpio_dual_irq_bank_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed register reads.
module gpio_dual_irq_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 32'h0;
    logic [31:0] pin_out, pin_drive;
    logic        irq_l1, irq_l2;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    gpio_dual_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive(pin_drive), .irq_l1(irq_l1), .irq_l2(irq_l2)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_s1, m_s2, m_prev, m_st1, m_st2, m_en1, m_en2;
    logic [31:0] m_dir, m_dout, m_lo, m_hi, m_rise, m_fall, m_wake, m_dben, m_sysc;
    logic [7:0]  m_dbt;
    logic        m_srst, m_irq1, m_irq2;

    always @(posedge clk) begin : model
        logic [31:0] ev;
        logic [31:0] w;
        w = bus_wr ? bus_wdata : 32'h0;
        if (!rst_n || m_srst) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_st1 <= 0; m_st2 <= 0;
            m_en1 <= 0; m_en2 <= 0; m_dir <= 32'hFFFF_FFFF; m_dout <= 0;
            m_lo <= 0; m_hi <= 0; m_rise <= 0; m_fall <= 0; m_wake <= 0;
            m_dben <= 0; m_sysc <= 0; m_dbt <= 0; m_irq1 <= 0; m_irq2 <= 0;
            m_srst <= rst_n && bus_wr && bus_addr == 8'h10 && bus_wdata[1];
        end else begin
            m_srst <= bus_wr && bus_addr == 8'h10 && bus_wdata[1];
            for (int i = 0; i < 32; i++) begin
                ev[i] = (m_lo[i] && !m_s2[i]) || (m_hi[i] && m_s2[i])
                     || (m_rise[i] && m_s2[i] && !m_prev[i])
                     || (m_fall[i] && !m_s2[i] && m_prev[i]);
            end
            m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
            m_st1 <= (m_st1 | ev) & ~((bus_addr == 8'h18) ? w : 32'h0);
            m_st2 <= (m_st2 | ev) & ~((bus_addr == 8'h28) ? w : 32'h0);
            m_irq1 <= (m_st1 & m_en1) != 0;
            m_irq2 <= (m_st2 & m_en2) != 0;
            if (bus_wr) begin
                case (bus_addr)
                    8'h10: m_sysc <= bus_wdata & 32'hFFFF_FFFD;
                    8'h1C: m_en1  <= bus_wdata;
                    8'h64: m_en1  <= m_en1 | bus_wdata;
                    8'h60: m_en1  <= m_en1 & ~bus_wdata;
                    8'h2C: m_en2  <= bus_wdata;
                    8'h74: m_en2  <= m_en2 | bus_wdata;
                    8'h70: m_en2  <= m_en2 & ~bus_wdata;
                    8'h20: m_wake <= bus_wdata;
                    8'h84: m_wake <= m_wake | bus_wdata;
                    8'h80: m_wake <= m_wake & ~bus_wdata;
                    8'h34: m_dir  <= bus_wdata;
                    8'h3C: m_dout <= bus_wdata;
                    8'h94: m_dout <= m_dout | bus_wdata;
                    8'h90: m_dout <= m_dout & ~bus_wdata;
                    8'h40: m_lo   <= bus_wdata;
                    8'h44: m_hi   <= bus_wdata;
                    8'h48: m_rise <= bus_wdata;
                    8'h4C: m_fall <= bus_wdata;
                    8'h50: m_dben <= bus_wdata;
                    8'h54: m_dbt  <= bus_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h10: return m_sysc;
            8'h14: return {31'h0, !m_srst};
            8'h18: return m_st1;
            8'h28: return m_st2;
            8'h1C, 8'h60, 8'h64: return m_en1;
            8'h2C, 8'h70, 8'h74: return m_en2;
            8'h20, 8'h80, 8'h84: return m_wake;
            8'h34: return m_dir;
            8'h38: return m_s2;
            8'h3C, 8'h90, 8'h94: return m_dout;
            8'h40: return m_lo;
            8'h44: return m_hi;
            8'h48: return m_rise;
            8'h4C: return m_fall;
            8'h50: return m_dben;
            8'h54: return {24'h0, m_dbt};
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of all outputs against the model (R1, R9, R6).
    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            chk(pin_drive, ~m_dir, "R1 pin_drive vs model");
            chk(pin_out, m_dout, "R9 pin_out vs model");
            chk({31'h0, irq_l1}, {31'h0, m_irq1}, "R6 irq_l1 vs model");
            chk({31'h0, irq_l2}, {31'h0, m_irq2}, "R6 irq_l2 vs model");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(bus_rdata, exp, tag);
        chk(bus_rdata, m_read(a), {tag, " vs model"});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    logic [7:0] sweep_ofs [24] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C, 8'h34,
                                   8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54,
                                   8'h60, 8'h64, 8'h70, 8'h74, 8'h80, 8'h84, 8'h90, 8'h94};

    task automatic sweep(input string tag);
        for (int k = 0; k < 24; k++) begin
            bus_addr = sweep_ofs[k];
            #1;
            chk(bus_rdata, m_read(sweep_ofs[k]), tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(2);

        // R11 reset state
        rd(8'h34, 32'hFFFF_FFFF, "R11 direction default");
        rd(8'h3C, 32'h0, "R11 output data default");
        rd(8'h48, 32'h0, "R11 rise default");
        rd(8'h1C, 32'h0, "R11 enable1 default");
        rd(8'h18, 32'h0, "R11 status1 default");
        chk({30'h0, irq_l2, irq_l1}, 32'h0, "R11 irq outputs low");
        rd(8'h14, 32'h1, "R10 reset done flag");

        // R1 direction and R9 set/clear output data
        wr(8'h34, 32'hFFFF_0000);
        wr(8'h94, 32'h0000_00A5);
        chk(pin_drive, 32'h0000_FFFF, "R1 low half driven");
        chk(pin_out, 32'h0000_00A5, "R9 set alias drives pins");
        rd(8'h90, 32'h0000_00A5, "R9 clear alias reads data");
        wr(8'h90, 32'h0000_0005);
        rd(8'h3C, 32'h0000_00A0, "R9 clear alias clears ones only");

        // R2 two-flop synchronizer latency
        set_pins(32'h0001_0000);
        idle(1);
        rd(8'h38, 32'h0, "R2 not visible after one edge");
        idle(1);
        rd(8'h38, 32'h0001_0000, "R2 visible after two edges");

        // R3 rising edge, R5 status without enable
        wr(8'h48, 32'h0000_0010);
        set_pins(32'h0001_0010);
        idle(4);
        rd(8'h18, 32'h0000_0010, "R3 rising sets status1");
        rd(8'h28, 32'h0000_0010, "R5 rising sets status2 too");
        chk({31'h0, irq_l1}, 32'h0, "R5 masked line stays low");

        // R6 and R8 enable via set alias
        wr(8'h64, 32'h0000_0010);
        idle(1);
        chk({31'h0, irq_l1}, 32'h1, "R6 line1 rises after enable");
        chk({31'h0, irq_l2}, 32'h0, "R6 line2 independent");
        rd(8'h1C, 32'h0000_0010, "R8 enable1 after set");
        rd(8'h64, 32'h0000_0010, "R8 set alias reads enable");

        // R7 write-one-to-clear, edge not re-recorded
        wr(8'h18, 32'h0000_0010);
        idle(1);
        chk({31'h0, irq_l1}, 32'h0, "R7 line1 drops after clear");
        idle(3);
        rd(8'h18, 32'h0, "R3 held level gives no new edge");
        rd(8'h28, 32'h0000_0010, "R7 other line untouched");

        // R3 falling edge
        wr(8'h4C, 32'h0000_0010);
        wr(8'h28, 32'h0000_0010);
        set_pins(32'h0001_0000);
        idle(4);
        rd(8'h18, 32'h0000_0010, "R3 falling sets status1");
        rd(8'h28, 32'h0000_0010, "R3 falling sets status2");

        // R4 level high: re-set on the clock after clear
        wr(8'h44, 32'h0000_0200);
        set_pins(32'h0001_0200);
        idle(4);
        rd(8'h18, 32'h0000_0210, "R4 high level sets status1");
        wr(8'h18, 32'h0000_0200);
        rd(8'h18, 32'h0000_0010, "R4 level bit cleared for one clock");
        idle(1);
        rd(8'h18, 32'h0000_0210, "R4 level bit re-set next clock");

        // R4 level low on an already low pin, R6 line 2
        wr(8'h40, 32'h0010_0000);
        idle(2);
        rd(8'h28, 32'h0010_0210, "R4 low level sets status2");
        wr(8'h74, 32'h0010_0000);
        idle(1);
        chk({31'h0, irq_l2}, 32'h1, "R6 line2 rises after enable");
        set_pins(32'h0011_0200);
        idle(4);
        wr(8'h28, 32'h0010_0000);
        idle(3);
        rd(8'h28, 32'h0000_0210, "R4 low level gone after pin rises");
        chk({31'h0, irq_l2}, 32'h0, "R6 line2 low after clear");
        wr(8'h70, 32'h0010_0000);
        rd(8'h70, 32'h0, "R8 clear alias reads enable2");

        // R8 zero bits have no effect
        wr(8'h64, 32'h0);
        wr(8'h60, 32'h0);
        rd(8'h1C, 32'h0000_0010, "R8 zero writes keep enable1");

        // R12 placeholders and unmapped space
        wr(8'h84, 32'h0000_0003);
        wr(8'h54, 32'h0000_12AB);
        rd(8'h20, 32'h0000_0003, "R12 wakeup set alias stores");
        rd(8'h54, 32'h0000_00AB, "R12 debounce time is 8 bits");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R12 unmapped reads zero");
        sweep("R12 full map vs model");

        // R10 soft reset
        wr(8'h10, 32'h0000_0002);
        rd(8'h14, 32'h0, "R10 flag low during reset");
        idle(1);
        rd(8'h14, 32'h1, "R10 flag high after reset");
        rd(8'h34, 32'hFFFF_FFFF, "R10 direction back to inputs");
        rd(8'h1C, 32'h0, "R10 enable1 cleared");
        rd(8'h3C, 32'h0, "R10 output data cleared");
        idle(4);
        rd(8'h18, 32'h0, "R10 status stays clear");
        sweep("R10 full map vs model");

        idle(2);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule